// File: doc/BRIEF.md
# Dithered DAC Resolution Extender

This block lets a narrow DAC reach fractional output levels. A 16-bit setting carries a coarse DAC code in its upper byte and a fractional dither byte in its lower byte. On every update strobe, the block adds the dither byte into a wrapping fractional accumulator. It then drives the DAC with the coarse code, raised by one count on each update where that addition carries out.

Over 256 updates the bumps occur exactly as often as the dither value asks. An external low-pass filter therefore sees a mean of coarse + dither/256 DAC steps. Because this is a first-order carry scheme, the bumps are spread as evenly as possible. That keeps the ripple frequency high and easy to filter.

A parameter limits how many upper dither bits take part. With two bits kept, an 8-bit DAC gives quarter steps, which is 10-bit effective resolution. The analog DAC and its filter lie outside this block.

Top module: `dither_dac_extender`

## Requirements
- R1: A synchronous reset clears the fractional accumulator and sets the DAC code and the valid flag to 0. Because the accumulator is cleared, the first update after reset never bumps.
- R2: The valid flag is high for exactly the one cycle that follows each cycle in which the update strobe is high, and low otherwise.
- R3: While the update strobe is low, the DAC code and the accumulator hold their values.
- R4: On an update, the accumulator becomes (accumulator + dither) mod 256. The DAC code becomes the coarse code plus one when that sum is 256 or more, and the coarse code otherwise.
- R5: With a constant setting applied over 256 consecutive updates from reset, the number of bumped outputs equals the dither value.
- R6: A dither value of 0x80 bumps on every second update.
- R7: A dither value of 0x40 bumps on one of every four updates. A dither value of 0xC0 bumps on three of every four updates.
- R8: When the coarse code is 255 and a carry occurs, the output stays at 255 instead of wrapping.
- R9: A dither value of 0 never bumps, so the output equals the coarse code.
- R10: The setting is sampled only on a strobed cycle, as one 16-bit word. The coarse code is bits [15:8] and the dither is bits [7:0]. Changes to the setting between strobes have no effect.
- R11: For a coarse code below 255, the sum of 256 consecutive outputs from reset equals 256 × coarse + dither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe, one per output sample |
| setting_i | input | 16 | Coarse code [15:8] and dither byte [7:0] |
| dac_code_o | output | 8 | Code driven to the DAC |
| dac_valid_o | output | 1 | Pulses one cycle after each update |

## Verification
The assertions assume that the setting is only meaningful in cycles where the strobe is high. They also assume that reset is held across at least one clock edge, so the checks compare the output with the coarse code and carry seen at the previous strobe. The stimulus deliberately overwrites the setting with unrelated words in every idle cycle. It issues strobes both back to back and with gaps, and applies reset in the middle of a run. This keeps every result tied to the strobed word alone and covers both the hold case and the immediate-next-update case.

// File: rtl/dithdac_pkg.sv
package dithdac_pkg;

  // Widest accumulator the generic helpers below are written for.
  localparam int unsigned MAX_W = 16;

  // Fractional sum with the carry placed above the low MAX_W bits.
  function automatic logic [MAX_W:0] frac_sum(input logic [MAX_W-1:0] acc,
                                              input logic [MAX_W-1:0] step);
    return {1'b0, acc} + {1'b0, step};
  endfunction

  // Raise a code by one unless it already sits at the supplied ceiling.
  function automatic logic [MAX_W-1:0] bump_sat(input logic [MAX_W-1:0] code,
                                               input logic              bump,
                                               input logic [MAX_W-1:0] ceil);
    if (!bump || code == ceil) return code;
    return code + 1'b1;
  endfunction

endpackage

// File: rtl/dd_setting_split.sv
module dd_setting_split #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned FRAC_W      = 8,
  parameter int unsigned DITHER_USED = 8,
  localparam int unsigned SET_W      = CODE_W + FRAC_W
) (
  input  logic [SET_W-1:0]  setting_i,
  output logic [CODE_W-1:0] coarse_o,
  output logic [FRAC_W-1:0] dither_o
);
  logic [FRAC_W-1:0] raw_dither;

  assign coarse_o   = setting_i[SET_W-1:FRAC_W];
  assign raw_dither = setting_i[FRAC_W-1:0];

  // Keep only the upper dither bits the chosen effective resolution needs.
  generate
    if (DITHER_USED >= FRAC_W) begin : g_full
      assign dither_o = raw_dither;
    end else begin : g_trunc
      localparam int unsigned DROP = FRAC_W - DITHER_USED;
      assign dither_o = {raw_dither[FRAC_W-1 -: DITHER_USED], {DROP{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/dd_frac_accum.sv
module dd_frac_accum
  import dithdac_pkg::*;
#(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              upd_i,
  input  logic [FRAC_W-1:0] dither_i,
  output logic              carry_o,
  output logic [FRAC_W-1:0] acc_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [MAX_W:0]    wide_sum;
  logic [FRAC_W:0]   step_sum;

  assign wide_sum = frac_sum(MAX_W'(acc_q), MAX_W'(dither_i));
  assign step_sum = wide_sum[FRAC_W:0];

  // Carry event for this update only.
  assign carry_o = upd_i & step_sum[FRAC_W];
  assign acc_o   = acc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      acc_q <= '0;
    else if (upd_i) acc_q <= step_sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/dd_code_stage.sv
module dd_code_stage
  import dithdac_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              upd_i,
  input  logic              carry_i,
  input  logic [CODE_W-1:0] coarse_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [MAX_W-1:0]  wide_next;
  logic [CODE_W-1:0] next_code;

  assign wide_next = bump_sat(MAX_W'(coarse_i), carry_i, MAX_W'(CODE_MAX));
  assign next_code = wide_next[CODE_W-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= upd_i;
      if (upd_i) code_o <= next_code;
    end
  end
endmodule

// File: rtl/dither_dac_extender.sv
module dither_dac_extender #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned FRAC_W      = 8,
  parameter int unsigned DITHER_USED = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       upd_i,
  input  logic [CODE_W+FRAC_W-1:0]   setting_i,
  output logic [CODE_W-1:0]          dac_code_o,
  output logic                       dac_valid_o
);
  // Named internal events, brought out for the bound checker.
  logic [CODE_W-1:0] coarse_w;
  logic [FRAC_W-1:0] dither_w;
  logic [FRAC_W-1:0] acc_w;
  logic              carry_w;

  dd_setting_split #(
    .CODE_W(CODE_W), .FRAC_W(FRAC_W), .DITHER_USED(DITHER_USED)
  ) u_split (
    .setting_i(setting_i),
    .coarse_o (coarse_w),
    .dither_o (dither_w)
  );

  dd_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .upd_i   (upd_i),
    .dither_i(dither_w),
    .carry_o (carry_w),
    .acc_o   (acc_w)
  );

  dd_code_stage #(.CODE_W(CODE_W)) u_code (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .upd_i   (upd_i),
    .carry_i (carry_w),
    .coarse_i(coarse_w),
    .code_o  (dac_code_o),
    .valid_o (dac_valid_o)
  );
endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned FRAC_W = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              upd_i,
  input logic [CODE_W-1:0] coarse_i,
  input logic [FRAC_W-1:0] dither_i,
  input logic [FRAC_W-1:0] acc_i,
  input logic              carry_i,
  input logic [CODE_W-1:0] code_i,
  input logic              valid_i
);
  localparam logic [CODE_W-1:0] TOP = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (code_i == '0) && !valid_i && (acc_i == '0));

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_i |=> valid_i);

  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !upd_i |=> !valid_i);

  // R3
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !upd_i |=> ($stable(code_i) && $stable(acc_i)));

  // R4
  bump_rule_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_i |=> code_i == (($past(carry_i) && $past(coarse_i) != TOP)
                          ? CODE_W'($past(coarse_i) + 1'b1) : $past(coarse_i)));

  // R8
  saturate_top_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_i && coarse_i == TOP) |=> code_i == TOP);

  // R9
  zero_dither_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_i && dither_i == '0) |=> code_i == $past(coarse_i));
endmodule

bind dither_dac_extender dd_checker #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .upd_i   (upd_i),
  .coarse_i(coarse_w),
  .dither_i(dither_w),
  .acc_i   (acc_w),
  .carry_i (carry_w),
  .code_i  (dac_code_o),
  .valid_i (dac_valid_o)
);

// File: tb/tb_dither_dac_extender.sv
module tb_dither_dac_extender;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd = 1'b0;
  logic [15:0] setting = 16'h0000;
  logic [7:0]  dac_code;
  logic        dac_valid;

  dither_dac_extender dut (
    .clk_i(clk), .rst_i(rst), .upd_i(upd), .setting_i(setting),
    .dac_code_o(dac_code), .dac_valid_o(dac_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    exp_q[$];
  string tag_q[$];
  int    model_acc = 0;
  int    cur_n = 0;
  int    bump_cnt = 0;
  int    out_sum = 0;
  int    last_code = 0;
  int    cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent model: remainder arithmetic on integers.
  task automatic upd_once(input int n, input int d, input int gap, input string tag);
    int total;
    int e;
    @(negedge clk);
    total = model_acc + d;
    e = n;
    if (total > 255) begin
      if (n < 255) e = n + 1;
      total = total - 256;
    end
    model_acc = total;
    setting = 16'((n << 8) | d);
    upd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (gap > 0) begin
      @(negedge clk);
      upd = 1'b0;
      for (int g = 0; g < gap; g++) begin
        setting = ~setting ^ 16'h5A3C;  // R10: unrelated words between strobes
        if (g + 1 < gap) @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int k);
    @(negedge clk);
    upd = 1'b0;
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    upd = 1'b0;
    rst = 1'b1;
    model_acc = 0;
    exp_q.delete();
    tag_q.delete();
    last_code = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    bump_cnt = 0;
    out_sum = 0;
  endtask

  // Monitor: pops the scoreboard on every valid sample.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (dac_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected valid", 1, 0);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(int'(dac_code) == e, t, int'(dac_code), e);
            if (int'(dac_code) != cur_n) bump_cnt++;
            out_sum += int'(dac_code);
            last_code = int'(dac_code);
          end
        end else begin
          chk(int'(dac_code) == last_code, "R3 hold while idle", int'(dac_code), last_code);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        chk(1'b0, "watchdog", cyc, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  task automatic run_block(input int n, input int d, input int count, input int gap, input string tag);
    cur_n = n;
    bump_cnt = 0;
    out_sum = 0;
    for (int i = 0; i < count; i++) upd_once(n, d, (i % 3 == 0) ? gap : 0, tag);
    idle(2);
    chk(exp_q.size() == 0, "R2 every strobe gave one valid", exp_q.size(), 0);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(dac_code == 8'd0, "R1 code after reset", int'(dac_code), 0);
    chk(dac_valid == 1'b0, "R1 valid after reset", int'(dac_valid), 0);

    // R6 half step
    run_block(16, 8'h80, 8, 1, "R6 half step");
    chk(bump_cnt == 4, "R6 bumps in 8 updates", bump_cnt, 4);

    // R7 quarter steps
    do_reset();
    run_block(51, 8'h40, 8, 2, "R7 quarter");
    chk(bump_cnt == 2, "R7 0x40 bumps in 8", bump_cnt, 2);
    do_reset();
    run_block(51, 8'hC0, 8, 0, "R7 three quarter");
    chk(bump_cnt == 6, "R7 0xC0 bumps in 8", bump_cnt, 6);

    // R5 / R11 density and mean over 256 updates
    begin
      int ns[4] = '{100, 7, 200, 0};
      int ds[4] = '{8'h5A, 1, 8'hFF, 8'h80};
      for (int k = 0; k < 4; k++) begin
        do_reset();
        run_block(ns[k], ds[k], 256, 1, "R4 scoreboard");
        chk(bump_cnt == ds[k], "R5 bump count equals dither", bump_cnt, ds[k]);
        chk(out_sum == 256 * ns[k] + ds[k], "R11 mean of 256 outputs", out_sum, 256 * ns[k] + ds[k]);
      end
    end

    // R9 zero dither
    do_reset();
    run_block(42, 0, 20, 1, "R9 zero dither");
    chk(bump_cnt == 0, "R9 no bumps", bump_cnt, 0);

    // R8 saturation at top code
    do_reset();
    run_block(255, 8'hC0, 16, 1, "R8 saturate");
    chk(out_sum == 16 * 255, "R8 all outputs at top", out_sum, 16 * 255);

    // R10 setting changed between strobes has no effect
    do_reset();
    run_block(90, 8'h80, 2, 0, "R10 base");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      setting = 16'((i * 16'h1357) ^ 16'hFFFF);
    end
    @(negedge clk);
    chk(dac_code == 8'd91, "R10 output unchanged by idle setting", int'(dac_code), 91);

    // R1 mid-run reset clears accumulator: first update cannot bump
    run_block(60, 8'hC0, 3, 0, "R4 pre-reset");
    do_reset();
    @(negedge clk);
    chk(dac_code == 8'd0, "R1 code cleared mid-run", int'(dac_code), 0);
    run_block(60, 8'hC0, 1, 0, "R1 first update after reset");
    chk(bump_cnt == 0, "R1 no bump on first update", bump_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule